// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Unit

This block computes 1/D for a fixed-point operand D between one half (exclusive) and one (inclusive). A single quadratic evaluator does all the arithmetic. The evaluator is built from two multipliers, two adders and multiplexers that pick its variable and its three coefficients, and it works in Horner form ((p·y + q)·y + r). On the cycle a start is accepted, the evaluator forms a seed estimate from a fitted quadratic in D. On each later cycle the same hardware is given the coefficients (−D, 2, 0) and the fed-back estimate x, so it computes the Newton step x·(2 − x·D). Every step roughly doubles the number of correct bits.

A precision select chooses one of two modes. Single mode uses its own seed fit and two steps. Double mode uses a second fit and three steps. The result is an unsigned value with one integer bit. It stays valid from the done pulse until the next accepted start. A flag reports an operand that lies outside the legal range, and the result is then undefined. Normalisation, exponents and rounding to a floating-point format are done by the surrounding logic.

Top module: `recip_nr_top`

## Requirements
- R1: While reset is asserted and until the first accepted start, `busy_o`, `done_o` and `err_o` are 0 and `recip_o` is all zeros.
- R2: When `start_i` is high on a rising edge and `busy_o` is low, the start is accepted. `busy_o` is high from that edge on.
- R3: In single mode (`prec_i` = 0 at acceptance), `busy_o` stays high for exactly two cycles. `done_o` is then high for exactly one cycle, and it rises on the same edge where `busy_o` falls.
- R4: In double mode (`prec_i` = 1 at acceptance), `busy_o` stays high for exactly three cycles, followed by the same one-cycle `done_o` pulse.
- R5: The operand `d_i` is two's complement. Bit 53 is the sign, bit 52 is the units bit and bits 51:0 are the fraction. The result `recip_o` holds one integer bit (bit 52) and 52 fraction bits. In single mode, for every legal operand, the result is within 2^-23 of 1/D.
- R6: In double mode, for every legal operand, the result is within 2^-50 of 1/D.
- R7: In single mode, operand bits 29:0 are ignored. Two operands that differ only in those bits give identical results.
- R8: A start that arrives while `busy_o` is high is ignored. The running operation keeps its timing and its result is computed for its own operand.
- R9: `recip_o` and `err_o` hold their values from the done pulse until the next accepted start, whatever `d_i` and `prec_i` do.
- R10: `err_o` is 1 for an operand (after the R7 masking) that is negative, zero, at most 0.5 or above 1.0. It is 0 for an operand strictly above 0.5 and at most 1.0. It is valid from the cycle after acceptance on.
- R11: A change of `prec_i` while `busy_o` is high has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a reciprocal |
| prec_i | input | 1 | 0 = single mode, 1 = double mode |
| d_i | input | 54 | Operand D, two's complement with 52 fraction bits |
| busy_o | output | 1 | Evaluation passes in progress |
| done_o | output | 1 | One-cycle pulse when the result is final |
| err_o | output | 1 | Operand outside (0.5, 1] |
| recip_o | output | 53 | 1/D with 1 integer bit and 52 fraction bits |

## Verification
A wrong pass count or a stuck controller shows on `busy_o` and `done_o` within at most four cycles of a start, because the bench compares the handshake against its own model on every cycle. Several internal faults corrupt the estimate: a wrong coefficient, a swapped multiplexer, a lost feedback path or a bad shift. Because Newton steps square the error of the seed, any of these leaves far fewer correct bits at the done pulse. The bench measures that error exactly in integer arithmetic as |R·D − 1|. A faulty mask or range decode shows up as unequal results for operands that differ only in bits 29:0, or as a wrong `err_o` at the same done pulse.

// File: rtl/recip_pkg.sv
package recip_pkg;

   typedef enum logic {
      PREC_SINGLE = 1'b0,
      PREC_DOUBLE = 1'b1
   } prec_e;

   // Converts a real constant to a signed fixed-point integer with f fraction bits.
   function automatic longint fix_of(real v, int f);
      return longint'(v * (2.0 ** f));
   endfunction

endpackage

// File: rtl/recip_fxmul.sv
module recip_fxmul #(
   parameter int W = 64,
   parameter int F = 60
) (
   input  logic signed [W-1:0] a_i,
   input  logic signed [W-1:0] b_i,
   output logic signed [W-1:0] p_o
);
   localparam int PW = 2 * W;

   logic signed [PW-1:0] full;

   assign full = PW'(a_i) * PW'(b_i);
   // arithmetic shift drops fraction bits, i.e. truncation toward minus infinity
   assign p_o  = W'(full >>> F);

endmodule

// File: rtl/recip_horner.sv
module recip_horner #(
   parameter int W = 64,
   parameter int F = 60
) (
   input  logic signed [W-1:0] y_i,
   input  logic signed [W-1:0] p_i,
   input  logic signed [W-1:0] q_i,
   input  logic signed [W-1:0] r_i,
   output logic signed [W-1:0] z_o
);
   localparam int ORDER = 2;

   logic signed [W-1:0] coef [0:ORDER];
   logic signed [W-1:0] acc  [0:ORDER];

   assign coef[0] = p_i;
   assign coef[1] = q_i;
   assign coef[2] = r_i;
   assign acc[0]  = coef[0];

   // Horner chain: acc[k+1] = acc[k]*y + coef[k+1]
   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic signed [W-1:0] prod;
      recip_fxmul #(.W(W), .F(F)) u_mul (
         .a_i(acc[k]),
         .b_i(y_i),
         .p_o(prod)
      );
      assign acc[k+1] = prod + coef[k+1];
   end

   assign z_o = acc[ORDER];

endmodule

// File: rtl/recip_coef.sv
module recip_coef
   import recip_pkg::*;
#(
   parameter int W = 64,
   parameter int F = 60
) (
   input  logic                seed_i,
   input  prec_e               prec_i,
   input  logic signed [W-1:0] d_i,
   output logic signed [W-1:0] p_o,
   output logic signed [W-1:0] q_o,
   output logic signed [W-1:0] r_o
);
   localparam logic signed [W-1:0] SQ_SGL = W'(fix_of( 2.65548, F));
   localparam logic signed [W-1:0] LN_SGL = W'(fix_of(-5.92781, F));
   localparam logic signed [W-1:0] K0_SGL = W'(fix_of( 4.28387, F));
   localparam logic signed [W-1:0] SQ_DBL = W'(fix_of( 2.60477, F));
   localparam logic signed [W-1:0] LN_DBL = W'(fix_of(-5.84702, F));
   localparam logic signed [W-1:0] K0_DBL = W'(fix_of( 4.25284, F));
   localparam logic signed [W-1:0] TWO    = W'(fix_of( 2.0,     F));

   always_comb begin
      if (seed_i) begin
         if (prec_i == PREC_DOUBLE) begin
            p_o = SQ_DBL;
            q_o = LN_DBL;
            r_o = K0_DBL;
         end else begin
            p_o = SQ_SGL;
            q_o = LN_SGL;
            r_o = K0_SGL;
         end
      end else begin
         p_o = -d_i;
         q_o = TWO;
         r_o = '0;
      end
   end

endmodule

// File: rtl/recip_ctrl.sv
module recip_ctrl
   import recip_pkg::*;
#(
   parameter int ITER_SGL = 2,
   parameter int ITER_DBL = 3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  prec_e prec_i,
   output logic  load_o,
   output logic  step_o,
   output logic  busy_o,
   output logic  done_o
);
   localparam int MAX_IT = (ITER_DBL > ITER_SGL) ? ITER_DBL : ITER_SGL;
   localparam int CNT_W  = $clog2(MAX_IT + 1);

   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] left_q;

   assign load_o = start_i && !busy_q;
   assign step_o = busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         left_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            busy_q <= 1'b1;
            left_q <= (prec_i == PREC_DOUBLE) ? CNT_W'(ITER_DBL) : CNT_W'(ITER_SGL);
         end else if (busy_q) begin
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assert_done_single_cycle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_done_at_busy_fall_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);

   assert_done_needs_pass_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(busy_q));

   assert_no_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && left_q != CNT_W'(1)) |=> (busy_q && $stable(done_q)));

   assert_count_live_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q != '0));

endmodule

// File: rtl/recip_nr_top.sv
module recip_nr_top
   import recip_pkg::*;
#(
   parameter int OP_W     = 54,
   parameter int SGL_OP_W = 24,
   parameter int DP_W     = 64,
   parameter int FRAC_W   = 60,
   parameter int RES_F    = 52,
   parameter int ITER_SGL = 2,
   parameter int ITER_DBL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              prec_i,
   input  logic [OP_W-1:0]   d_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [RES_F:0]    recip_o
);
   localparam int OP_F     = OP_W - 2;
   localparam int SGL_DROP = OP_W - SGL_OP_W;
   localparam int SH       = FRAC_W - OP_F;
   localparam int EXT      = DP_W - OP_W - SH;
   localparam int INT_W    = DP_W - FRAC_W;
   localparam logic [OP_W-2:0] ONE_OP  = (OP_W-1)'(1) << OP_F;
   localparam logic [OP_W-2:0] HALF_OP = ONE_OP >> 1;

   if (DP_W > 64) begin : g_chk_dpw
      $error("DP_W above 64 cannot hold the coefficient constants");
   end
   if (INT_W < 4) begin : g_chk_int
      $error("datapath needs at least 4 integer bits");
   end
   if (SH < 1 || EXT < 1) begin : g_chk_align
      $error("operand does not fit the datapath format");
   end
   if (RES_F > FRAC_W) begin : g_chk_res
      $error("result fraction wider than datapath fraction");
   end
   if (SGL_OP_W > OP_W || SGL_OP_W < 3) begin : g_chk_sgl
      $error("single operand width out of range");
   end
   if (ITER_SGL < 1 || ITER_DBL < 1) begin : g_chk_iter
      $error("each mode needs at least one Newton step");
   end

   prec_e               prec_sel;
   logic [OP_W-1:0]     d_eff;
   logic signed [DP_W-1:0] d_ext;
   logic                in_range;
   logic                load, step;
   logic signed [DP_W-1:0] y_mux, p_c, q_c, r_c, z;
   logic signed [DP_W-1:0] d_q, x_q;
   logic                err_q;

   assign prec_sel = prec_e'(prec_i);

   // operand masking: single mode keeps only the upper SGL_OP_W bits
   if (SGL_DROP > 0) begin : g_mask
      assign d_eff = (prec_sel == PREC_DOUBLE) ? d_i
                                               : {d_i[OP_W-1:SGL_DROP], {SGL_DROP{1'b0}}};
   end else begin : g_nomask
      assign d_eff = d_i;
   end

   assign d_ext    = {{EXT{d_eff[OP_W-1]}}, d_eff, {SH{1'b0}}};
   assign in_range = !d_eff[OP_W-1] && (d_eff[OP_W-2:0] > HALF_OP)
                     && (d_eff[OP_W-2:0] <= ONE_OP);

   recip_ctrl #(.ITER_SGL(ITER_SGL), .ITER_DBL(ITER_DBL)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .prec_i (prec_sel),
      .load_o (load),
      .step_o (step),
      .busy_o (busy_o),
      .done_o (done_o)
   );

   // seed pass uses the live operand, later passes the fed-back estimate
   assign y_mux = load ? d_ext : x_q;

   recip_coef #(.W(DP_W), .F(FRAC_W)) u_coef (
      .seed_i(load),
      .prec_i(prec_sel),
      .d_i   (d_q),
      .p_o   (p_c),
      .q_o   (q_c),
      .r_o   (r_c)
   );

   recip_horner #(.W(DP_W), .F(FRAC_W)) u_eval (
      .y_i(y_mux),
      .p_i(p_c),
      .q_i(q_c),
      .r_i(r_c),
      .z_o(z)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_q   <= '0;
         x_q   <= '0;
         err_q <= 1'b0;
      end else begin
         if (load) begin
            d_q   <= d_ext;
            err_q <= !in_range;
         end
         if (load || step) begin
            x_q <= z;
         end
      end
   end

   assign err_o   = err_q;
   assign recip_o = x_q[FRAC_W -: RES_F+1];

   assert_estimate_bounded_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !err_q) |-> (x_q[DP_W-1:FRAC_W+2] == '0 && x_q != '0));

   assert_result_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(recip_o));

   assert_flag_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o || !start_i) |=> $stable(err_o));

   assert_result_plausible_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (recip_o[RES_F] || recip_o[RES_F-1]));

endmodule

// File: tb/recip_nr_top_tb.sv
`timescale 1ns/1ps
module recip_nr_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        prec = 1'b0;
   logic [53:0] d = '0;
   logic        busy, done, err;
   logic [52:0] recip;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   longint cyc = 0;

   recip_nr_top u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .prec_i (prec),
      .d_i    (d),
      .busy_o (busy),
      .done_o (done),
      .err_o  (err),
      .recip_o(recip)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [53:0] masked(input logic [53:0] v, input bit dbl);
      return dbl ? v : {v[53:30], 30'b0};
   endfunction

   function automatic bit legal(input logic [53:0] v);
      return !v[53] && (v[52:0] > (53'd1 << 51)) && (v[52:0] <= (53'd1 << 52));
   endfunction

   // |R*D - 1| in units of 2^-104; bound 2^(103-k) gives |R - 1/D| <= 2^-k for D > 0.5
   function automatic logic [127:0] err_units(input logic [52:0] r, input logic [53:0] v);
      logic [127:0] prod, tgt;
      prod = 128'(r) * 128'(v[52:0]);
      tgt  = 128'(1) << 104;
      return (prod > tgt) ? prod - tgt : tgt - prod;
   endfunction

   function automatic logic [127:0] bound(input bit dbl);
      return dbl ? (128'(1) << 53) : (128'(1) << 80);
   endfunction

   // behavioural reference model, advanced on every rising edge
   bit          m_busy = 0, m_done = 0, m_dbl = 0, m_hold_ok = 0;
   int          m_left = 0;
   logic [53:0] m_d = '0;
   logic [52:0] m_hold = '0;
   bit          m_err_hold = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_left = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_busy = 0;
               m_done = 1;
            end
         end else if (start) begin
            m_busy = 1;
            m_dbl  = prec;
            m_d    = masked(d, prec);
            m_left = prec ? 3 : 2;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy == m_busy, m_dbl ? "R4" : "R3", "busy", 128'(busy), 128'(m_busy));
         chk(done == m_done, m_dbl ? "R4" : "R3", "done", 128'(done), 128'(m_done));
         if (m_done) begin
            chk(err == !legal(m_d), "R10", "err at done", 128'(err), 128'(!legal(m_d)));
            if (legal(m_d))
               chk(err_units(recip, m_d) <= bound(m_dbl), m_dbl ? "R6" : "R5",
                   "accuracy", err_units(recip, m_d), bound(m_dbl));
            m_hold = recip;
            m_err_hold = err;
            m_hold_ok = 1;
         end else if (!m_busy && m_hold_ok) begin
            chk(recip == m_hold, "R9", "result hold", 128'(recip), 128'(m_hold));
            chk(err == m_err_hold, "R9", "flag hold", 128'(err), 128'(m_err_hold));
         end
      end
   end

   task automatic finish_up();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 60000 && !finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<=60000", cyc);
         finish_up();
      end
   end

   task automatic run(input logic [53:0] v, input bit dbl, output logic [52:0] res,
                      output bit e);
      @(negedge clk);
      start = 1'b1; d = v; prec = dbl;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 8 && !done; i++) @(negedge clk);
      res = recip;
      e = err;
   endtask

   initial begin
      logic [52:0] r1, r2;
      bit e1;
      logic [63:0] lcg;
      lcg = 64'h1234_5678_9abc_def1;
      repeat (4) @(negedge clk);
      chk(busy == 0 && done == 0 && err == 0, "R1", "flags in reset",
          {busy, done, err}, 0);
      chk(recip == 0, "R1", "result in reset", 128'(recip), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && recip == 0, "R1", "idle after reset",
          128'(recip), 0);

      // directed legal operands, both modes (R2..R6 checked by the monitor)
      for (int m = 0; m < 2; m++) begin
         run(54'd1 << 52, m[0], r1, e1);
         chk(r1 == (53'd1 << 52) || r1 == (53'd1 << 52) - 1 || err_units(r1, 54'd1 << 52) <= bound(m[0]),
             m[0] ? "R6" : "R5", "D=1", 128'(r1), 128'(53'd1 << 52));
         run((54'd1 << 51) + 1, m[0], r1, e1);
         run((54'd1 << 51) + (54'd1 << 30), m[0], r1, e1);
         run((54'd1 << 52) - 1, m[0], r1, e1);
         run(54'd3 << 50, m[0], r1, e1);
         run(54'h9_9999_9999_999A, m[0], r1, e1);
      end

      // pseudo-random legal operands
      for (int i = 0; i < 120; i++) begin
         lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
         run((54'd1 << 51) + 1 + 54'(lcg[63:13] % (64'd1 << 51)), i[0], r1, e1);
         chk(e1 == 0, "R10", "legal flag", 128'(e1), 0);
      end

      // R7: low operand bits ignored in single mode
      run((54'd5 << 49) | 54'h2AAA_AAAA, 1'b0, r1, e1);
      run((54'd5 << 49) | 54'h1555_5555, 1'b0, r2, e1);
      chk(r1 == r2, "R7", "masked low bits", 128'(r1), 128'(r2));
      run(54'h0F_0F0F_C000_0000 | 54'h3FFF_FFFF, 1'b0, r1, e1);
      run(54'h0F_0F0F_C000_0000, 1'b0, r2, e1);
      chk(r1 == r2, "R7", "masked low bits set", 128'(r1), 128'(r2));

      // R8 / R11: start and precision changes while busy are ignored
      @(negedge clk);
      start = 1'b1; d = 54'h0B_0000_0000_1234; prec = 1'b1;
      @(negedge clk);
      d = 54'h0F_FFFF_0000_0000; prec = 1'b0;
      @(negedge clk);
      prec = 1'b1;
      @(negedge clk);
      prec = 1'b0; start = 1'b0;
      for (int i = 0; i < 8 && !done; i++) @(negedge clk);
      chk(err_units(recip, 54'h0B_0000_0000_1234) <= bound(1'b1), "R8",
          "busy start ignored", err_units(recip, 54'h0B_0000_0000_1234), bound(1'b1));
      chk(done == 1'b1, "R11", "double timing kept", 128'(done), 1);

      // back-to-back: start held so it is taken right after done
      @(negedge clk);
      start = 1'b1; d = 54'h0C_0000_0000_0000; prec = 1'b0;
      repeat (3) @(negedge clk);
      d = 54'h0E_0000_0000_0000;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);

      // R10: illegal operands
      run(54'd1 << 51, 1'b1, r1, e1);
      chk(e1 == 1, "R10", "D=0.5", 128'(e1), 1);
      run(54'd0, 1'b0, r1, e1);
      chk(e1 == 1, "R10", "D=0", 128'(e1), 1);
      run(54'h30_0000_0000_0000, 1'b1, r1, e1);
      chk(e1 == 1, "R10", "negative D", 128'(e1), 1);
      run((54'd1 << 52) + 1, 1'b1, r1, e1);
      chk(e1 == 1, "R10", "D above 1 double", 128'(e1), 1);
      run((54'd1 << 52) + (54'd1 << 30), 1'b0, r1, e1);
      chk(e1 == 1, "R10", "D above 1 single", 128'(e1), 1);
      run((54'd1 << 52) + 1, 1'b0, r1, e1);
      chk(e1 == 0, "R10", "D above 1 masked to 1 in single", 128'(e1), 0);

      // R9: idle with moving inputs
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         d = 54'(i * 54'h1_2345_6789_ABCD);
         prec = i[0];
      end
      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule